// File: doc/BRIEF.md
# UART with selectable FIFO buffering

This block is an asynchronous serial transmitter and receiver for 8-bit frames. A host side with plain strobes writes bytes to send and pops received bytes. One configuration bit picks the buffering. In single mode each direction holds one byte. In FIFO mode each direction has a 16-entry queue. Each receive entry then carries the byte's own parity and framing status, so a host reading the 16-bit word can tell which entries are bad.

A programmable divisor produces an oversampling tick at 16 ticks per bit. The transmit engine steps through the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP:
- TX_IDLE goes to TX_START when a byte is loaded.
- TX_START goes to TX_DATA after one bit time.
- TX_DATA goes to TX_PARITY, or to TX_STOP when parity is disabled, after the eighth data bit.
- TX_PARITY goes to TX_STOP after one bit time.
- TX_STOP goes back to TX_IDLE after one bit time.

The receive engine steps through RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP:
- RX_IDLE goes to RX_START when the line is low.
- RX_START returns to RX_IDLE if the line is high at the half-bit point, and otherwise goes to RX_DATA.
- RX_DATA goes to RX_PARITY or RX_STOP after the eighth mid-bit sample.
- RX_PARITY goes to RX_STOP after its sample.
- RX_STOP goes back to RX_IDLE at the stop-bit sample, which also delivers the byte.

In FIFO mode the transmitter waits until enough bytes are queued. Once started, it drains the queue to empty before it waits for the trigger count again.

Top module: `uart_fifo_core`

## Requirements
- R1: `cfg_fifo_mode` = 0 selects single mode, with one receive and one transmit stage. `cfg_fifo_mode` = 1 selects FIFO mode, with 16 stages in each direction.
- R2: The frame is one low start bit, then 8 data bits LSB first, then an even parity bit only when `cfg_par_en` = 1, then one high stop bit. Each bit lasts 16 ticks, and a tick occurs every `cfg_div`+1 clock cycles.
- R3: In single mode a received byte raises `rx_avail` and appears as `host_rdata` = {8'h00, byte}. `irq_rx_done` pulses for one cycle for each byte stored.
- R4: In single mode a byte that completes while the held byte is unread is dropped and the held byte is kept. `irq_rx_err` pulses, and the sticky `ovr_flag` is set until reset.
- R5: In FIFO mode a receive entry is {6'b0, framing error at bit 9, parity error at bit 8, data at bits 7:0}.
- R6: A received parity bit that makes the total count of ones odd is a parity error. A low level at the stop-bit sample is a framing error. Either error pulses `irq_rx_err`, and the byte is still stored.
- R7: In FIFO mode a byte arriving at a full receive FIFO is dropped, pulses `irq_rx_err` and sets `ovr_flag`. The 16 stored entries are unchanged.
- R8: A falling edge on `rxd` whose line is high again at the half-bit point produces no byte and no interrupt.
- R9: In FIFO mode transmission starts only when `cfg_tx_en` = 1 and the transmit FIFO holds at least `cfg_trig`+1 bytes. Once started, it continues until the FIFO is empty.
- R10: A host write to a full transmit stage or a full transmit FIFO is ignored.
- R11: `irq_tx_req` pulses once when the single transmit stage is handed to the engine, or when the last byte leaves the transmit FIFO.
- R12: After reset `txd` is high, `rx_avail` is 0, `ovr_flag` is 0 and no interrupt is pulsing.
- R13: The FIFOs keep first-in first-out order in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_mode | input | 1 | 0 = single mode, 1 = FIFO mode |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_par_en | input | 1 | Even parity bit present |
| cfg_trig | input | 4 | Transmit trigger; start threshold is value+1 bytes |
| cfg_div | input | DIV_W | Tick divisor; tick period is value+1 clocks |
| host_wr | input | 1 | Write strobe for a transmit byte |
| host_wdata | input | 8 | Transmit byte |
| host_rd | input | 1 | Pop strobe for the receive side |
| host_rdata | output | 16 | Head receive word |
| rx_avail | output | 1 | Receive data present |
| ovr_flag | output | 1 | Sticky receive overrun |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq_rx_done | output | 1 | Byte stored pulse |
| irq_rx_err | output | 1 | Overrun, parity or framing error pulse |
| irq_tx_req | output | 1 | Transmit storage freed pulse |

## Verification
A receive engine stuck outside RX_IDLE shows at the ports within one frame time: the next byte never raises `irq_rx_done`. A wrong bit counter shows as a corrupted byte or a misplaced error bit in the first word read. A wrong FIFO pointer or count shows as reordered, missing or extra words when the queue is read back, or as an overrun flagged one entry early or late. A bad trigger latch shows as `txd` leaving its high level before the threshold is reached, or as a queue that stops part-way. Looping `txd` back to `rxd`, any transmit-side fault appears in the received words about one frame later.

// File: rtl/uart_pkg.sv
package uart_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2: tick spacing never shorter than the divisor allows
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R10 / R7: a push into a full queue leaves it full, never wraps
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));
    // R13: popping an empty queue keeps it empty
    assert_no_underflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int OVS   = 16,
    localparam int SW   = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              txd,
    output logic              busy
);
    tx_state_e         state, nxt;
    logic [SW-1:0]     cnt;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic              par;
    logic              bit_end;

    assign bit_end = tick && (cnt == SW'(OVS - 1));
    assign busy    = (state != TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (start) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bitn == 3'd7) nxt = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (bit_end) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            par   <= 1'b0;
        end else if (state == TX_IDLE) begin
            cnt  <= '0;
            bitn <= '0;
            if (start) begin
                shreg <= data;
                par   <= ^data;
            end
        end else if (tick) begin
            cnt <= cnt + 1'b1;
            if (bit_end && state == TX_DATA) begin
                shreg <= shreg >> 1;
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    // R2: an accepted load drives the start bit on the next cycle
    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == TX_IDLE) |=> !txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int OVS   = 16,
    localparam int SW   = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              rxd,
    output logic              done,
    output logic [BYTE_W-1:0] data,
    output logic              pe,
    output logic              fe
);
    rx_state_e         state, nxt;
    logic [1:0]        sync;
    logic              rxd_s;
    logic [SW-1:0]     cnt;
    logic [2:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic              pbit;
    logic              mid, half;

    assign rxd_s = sync[1];
    assign mid   = tick && (cnt == SW'(OVS - 1));
    assign half  = tick && (cnt == SW'(OVS / 2 - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (!rxd_s) nxt = RX_START;
            RX_START:  if (half) nxt = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (mid && bitn == 3'd7) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (mid) nxt = RX_STOP;
            RX_STOP:   if (mid) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            data  <= '0;
            pe    <= 1'b0;
            fe    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                end
                RX_START: if (tick) cnt <= half ? '0 : cnt + 1'b1;
                RX_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) begin
                        shreg <= {rxd_s, shreg[BYTE_W-1:1]};
                        bitn  <= bitn + 1'b1;
                    end
                end
                RX_PARITY: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) pbit <= rxd_s;
                end
                RX_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) begin
                        done <= 1'b1;
                        data <= shreg;
                        pe   <= par_en && ((^shreg) != pbit);
                        fe   <= !rxd_s;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R8: a start bit that is high again at the half-bit point is abandoned
    assert_start_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && half && rxd_s) |=> (state == RX_IDLE && !done));
    // R2: a byte is only delivered out of the stop-bit state
    assert_done_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
    import uart_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fifo_mode,
    input  logic             cfg_tx_en,
    input  logic             cfg_par_en,
    input  logic [3:0]       cfg_trig,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic             host_rd,
    output logic [15:0]      host_rdata,
    output logic             rx_avail,
    output logic             ovr_flag,
    output logic             txd,
    input  logic             rxd,
    output logic             irq_rx_done,
    output logic             irq_rx_err,
    output logic             irq_tx_req
);
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int RXE_W = BYTE_W + 2;

    logic              tick;
    logic              rx_done, rx_pe, rx_fe;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_busy, tx_load;
    logic [BYTE_W-1:0] tx_data;

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick));

    uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(cfg_par_en), .rxd(rxd),
        .done(rx_done), .data(rx_byte), .pe(rx_pe), .fe(rx_fe));

    uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(cfg_par_en),
        .start(tx_load), .data(tx_data), .txd(txd), .busy(tx_busy));

    // ---------------- receive storage ----------------
    logic [RXE_W-1:0]  rxf_head;
    logic [CW-1:0]     rxf_count;
    logic              rxf_full;
    logic [BYTE_W-1:0] rx_hold;
    logic              rx_hfull;
    logic              rx_drop;

    uart_fifo #(.W(RXE_W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_done && cfg_fifo_mode), .wdata({rx_fe, rx_pe, rx_byte}),
        .pop(host_rd && cfg_fifo_mode), .rdata(rxf_head), .count(rxf_count));

    assign rxf_full = (rxf_count == CW'(DEPTH));
    assign rx_drop  = rx_done && (cfg_fifo_mode ? rxf_full : rx_hfull);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold     <= '0;
            rx_hfull    <= 1'b0;
            ovr_flag    <= 1'b0;
            irq_rx_done <= 1'b0;
            irq_rx_err  <= 1'b0;
        end else begin
            if (!cfg_fifo_mode && rx_done && !rx_hfull) begin
                rx_hold  <= rx_byte;
                rx_hfull <= 1'b1;
            end else if (!cfg_fifo_mode && host_rd) begin
                rx_hfull <= 1'b0;
            end
            if (rx_drop) ovr_flag <= 1'b1;
            irq_rx_done <= rx_done && !rx_drop;
            irq_rx_err  <= rx_drop || (rx_done && (rx_pe || rx_fe));
        end
    end

    assign host_rdata = cfg_fifo_mode ? {{(16 - RXE_W){1'b0}}, rxf_head}
                                      : {8'h00, rx_hold};
    assign rx_avail   = cfg_fifo_mode ? (rxf_count != '0) : rx_hfull;

    // ---------------- transmit storage ----------------
    logic [BYTE_W-1:0] txf_head, tx_hold;
    logic [CW-1:0]     txf_count, thr;
    logic              tx_hfull, drain, go_f, go_s;

    uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(host_wr && cfg_fifo_mode), .wdata(host_wdata),
        .pop(tx_load && cfg_fifo_mode), .rdata(txf_head), .count(txf_count));

    assign thr     = CW'(cfg_trig) + CW'(1);
    assign go_f    = cfg_fifo_mode && cfg_tx_en && (txf_count != '0) && (drain || txf_count >= thr);
    assign go_s    = !cfg_fifo_mode && cfg_tx_en && tx_hfull;
    assign tx_load = !tx_busy && (go_f || go_s);
    assign tx_data = cfg_fifo_mode ? txf_head : tx_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold    <= '0;
            tx_hfull   <= 1'b0;
            drain      <= 1'b0;
            irq_tx_req <= 1'b0;
        end else begin
            if (!cfg_fifo_mode && host_wr && !tx_hfull) begin
                tx_hold  <= host_wdata;
                tx_hfull <= 1'b1;
            end else if (tx_load && !cfg_fifo_mode) begin
                tx_hfull <= 1'b0;
            end
            if (tx_load && cfg_fifo_mode && txf_count == CW'(1) && !host_wr)
                drain <= 1'b0;
            else if (cfg_fifo_mode && cfg_tx_en && txf_count >= thr)
                drain <= 1'b1;
            irq_tx_req <= tx_load && (!cfg_fifo_mode || txf_count == CW'(1));
        end
    end

    // R4 / R7: overrun flag is sticky
    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> ovr_flag);
    // R3: a stored-byte pulse always leaves data visible to the host
    assert_avail_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx_done && !$past(host_rd)) |-> rx_avail);
    // R11: in FIFO mode the request pulse means the queue ran dry
    assert_tx_req_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx_req && cfg_fifo_mode && !$past(host_wr)) |-> (txf_count == '0));
    // R9: the transmitter never starts a FIFO burst below the threshold
    assert_tx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_mode && $rose(tx_busy) && !$past(drain)) |-> $past(txf_count >= thr));
endmodule

// File: tb/uart_fifo_core_test.sv
`timescale 1ns/1ps
module uart_fifo_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_mode = 1'b0, cfg_tx_en = 1'b0, cfg_par_en = 1'b0;
    logic [3:0]  cfg_trig = 4'd0;
    logic [15:0] cfg_div = 16'd0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [15:0] host_rdata;
    logic        rx_avail, ovr_flag, txd, irq_rx_done, irq_rx_err, irq_tx_req;
    logic        drv_rxd = 1'b1, loop_en = 1'b0;
    logic        rxd_line;

    int checks = 0, fails = 0;
    int n_done = 0, n_err = 0, n_txreq = 0, n_txlow = 0;

    always #2 clk = ~clk;
    assign rxd_line = loop_en ? txd : drv_rxd;

    uart_fifo_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_mode(cfg_fifo_mode), .cfg_tx_en(cfg_tx_en),
        .cfg_par_en(cfg_par_en), .cfg_trig(cfg_trig), .cfg_div(cfg_div),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .rx_avail(rx_avail), .ovr_flag(ovr_flag),
        .txd(txd), .rxd(rxd_line), .irq_rx_done(irq_rx_done),
        .irq_rx_err(irq_rx_err), .irq_tx_req(irq_tx_req));

    always @(negedge clk) begin
        if (irq_rx_done) n_done++;
        if (irq_rx_err)  n_err++;
        if (irq_tx_req)  n_txreq++;
        if (!txd)        n_txlow++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic fifo, input logic par);
        @(negedge clk);
        rst_n = 1'b0; loop_en = 1'b0; drv_rxd = 1'b1; cfg_tx_en = 1'b0;
        cfg_fifo_mode = fifo; cfg_par_en = par; cfg_trig = 4'd0;
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic hold_line(input logic v, input int n);
        drv_rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // bit time is 16 clocks with cfg_div = 0
    task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        hold_line(1'b0, 16);
        for (int i = 0; i < 8; i++) hold_line(b[i], 16);
        if (cfg_par_en) hold_line((^b) ^ bad_par, 16);
        hold_line(!bad_stop, 13);
        hold_line(1'b1, 19);
    endtask

    task automatic read_word(input string tag, input logic [15:0] exp);
        @(negedge clk);
        chk({tag, " avail"}, rx_avail, 1'b1);
        chk({tag, " data"}, host_rdata, exp);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 1'b0);
        chk("R12 txd", txd, 1'b1);
        chk("R12 rx_avail", rx_avail, 1'b0);
        chk("R12 ovr_flag", ovr_flag, 1'b0);
        chk("R12 irqs", {irq_rx_done, irq_rx_err, irq_tx_req}, 3'b000);
    endtask

    task automatic t_single_rx_overrun();
        int d0, e0;
        do_reset(1'b0, 1'b0);
        d0 = n_done; e0 = n_err;
        send_frame(8'hA5, 1'b0, 1'b0);
        chk("R3 one done pulse", n_done - d0, 1);
        chk("R3 no error", n_err - e0, 0);
        send_frame(8'h5A, 1'b0, 1'b0);
        chk("R4 error pulse", n_err - e0, 1);
        chk("R4 sticky ovr", ovr_flag, 1'b1);
        chk("R4 no extra done", n_done - d0, 1);
        read_word("R3 R1 held byte kept", 16'h00A5);
        @(negedge clk);
        chk("R1 single stage empties", rx_avail, 1'b0);
        chk("R4 ovr still set", ovr_flag, 1'b1);
    endtask

    task automatic t_single_parity();
        int e0;
        do_reset(1'b0, 1'b1);
        e0 = n_err;
        send_frame(8'h81, 1'b1, 1'b0);
        chk("R6 parity err pulse", n_err - e0, 1);
        read_word("R6 byte still stored", 16'h0081);
    endtask

    task automatic t_fifo_rx_layout();
        int e0;
        do_reset(1'b1, 1'b1);
        e0 = n_err;
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b1, 1'b0);
        send_frame(8'h33, 1'b0, 1'b1);
        chk("R6 two error pulses", n_err - e0, 2);
        read_word("R5 R13 clean entry", 16'h0011);
        read_word("R5 parity bit8", 16'h0122);
        read_word("R5 framing bit9", 16'h0233);
        @(negedge clk);
        chk("R5 fifo empty", rx_avail, 1'b0);
    endtask

    task automatic t_fifo_rx_full();
        int d0, e0;
        do_reset(1'b1, 1'b0);
        d0 = n_done; e0 = n_err;
        for (int i = 0; i < 17; i++) send_frame(8'h60 + 8'(i), 1'b0, 1'b0);
        chk("R7 sixteen stored", n_done - d0, 16);
        chk("R7 one drop error", n_err - e0, 1);
        chk("R7 ovr set", ovr_flag, 1'b1);
        for (int i = 0; i < 16; i++) read_word("R7 R13 order", {8'h00, 8'h60 + 8'(i)});
        @(negedge clk);
        chk("R7 seventeenth dropped", rx_avail, 1'b0);
    endtask

    task automatic t_start_reject();
        int d0, e0;
        do_reset(1'b0, 1'b0);
        d0 = n_done; e0 = n_err;
        hold_line(1'b0, 4);
        hold_line(1'b1, 200);
        chk("R8 no byte", n_done - d0, 0);
        chk("R8 no error", n_err - e0, 0);
        chk("R8 nothing available", rx_avail, 1'b0);
    endtask

    task automatic t_single_tx();
        int q0;
        do_reset(1'b0, 1'b1);
        loop_en = 1'b1;
        q0 = n_txreq;
        write_byte(8'h3C);
        write_byte(8'h77);
        cfg_tx_en = 1'b1;
        repeat (220) @(negedge clk);
        chk("R11 one request", n_txreq - q0, 1);
        read_word("R2 loopback parity frame", 16'h003C);
        repeat (220) @(negedge clk);
        chk("R10 second write ignored", rx_avail, 1'b0);
        chk("R2 line idle high", txd, 1'b1);
    endtask

    task automatic t_fifo_trigger();
        int q0, l0;
        do_reset(1'b1, 1'b0);
        loop_en = 1'b1;
        cfg_trig = 4'd3;
        cfg_tx_en = 1'b1;
        q0 = n_txreq; l0 = n_txlow;
        write_byte(8'hC1); write_byte(8'hC2); write_byte(8'hC3);
        repeat (300) @(negedge clk);
        chk("R9 held below trigger", n_txlow - l0, 0);
        write_byte(8'hC4);
        repeat (800) @(negedge clk);
        chk("R11 one request at empty", n_txreq - q0, 1);
        for (int i = 0; i < 4; i++) read_word("R9 R13 burst", {8'h00, 8'hC1 + 8'(i)});
    endtask

    task automatic t_fifo_tx_full();
        do_reset(1'b1, 1'b0);
        loop_en = 1'b1;
        for (int i = 0; i < 17; i++) write_byte(8'h40 + 8'(i));
        cfg_trig = 4'd15;
        cfg_tx_en = 1'b1;
        repeat (2800) @(negedge clk);
        for (int i = 0; i < 16; i++) read_word("R10 R13 queued", {8'h00, 8'h40 + 8'(i)});
        @(negedge clk);
        chk("R10 seventeenth write ignored", rx_avail, 1'b0);
        chk("R9 drained to idle", txd, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_single_rx_overrun();
        t_single_parity();
        t_fifo_rx_layout();
        t_fifo_rx_full();
        t_start_reject();
        t_single_tx();
        t_fifo_trigger();
        t_fifo_tx_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule